// File: doc/BRIEF.md
# Startup Supply Current Sequencer

This block is the digital sequencer that governs a switchable high-voltage charging source feeding the controller's own supply capacitor. It watches six digitised comparator flags. Four describe the supply rail: above 1 V, at the start level, below the recharge level and below the undervoltage level. One says whether the drain voltage is high enough to draw charge from, and one says whether the main switch is currently in its off phase. From these it picks a charging-current level, enables the controller and holds the power gate low whenever the controller must not run.

At power-up the source first delivers a small current that is safe against a shorted supply pin. Once the rail is above 1 V it moves to a faster level. At the start level the controller runs and the source turns off. In self-supply mode the source comes back whenever the rail sags to the recharge level. It delivers the self-supply current only during the switch-off phase, and stops once the rail is back at the start level. In external-supply mode the rail is held up from outside and the source stays off while the controller runs. Every flag is resynchronised to the block clock before use.

Top module: `hv_supply_seq`

## Requirements
- R1: While the synchronised drain-high flag is 0, the source is never started: from the off or undervoltage state the current select stays 00. A drain-high flag going to 0 during either charging phase returns the block to the off state with select 00.
- R2: With the drain high and the rail below 1 V, the current select is 01 (low, short-safe). Once the rail is above 1 V during charging, the select is 10 (medium, fast).
- R3: When the rail reaches the start level during charging, run enable goes to 1, gate hold goes to 0 and the current select goes to 00.
- R4: In self-supply mode (ext_supply_i = 0), a running controller whose rail falls below the recharge level, with the drain high, enters recharge. Recharge lasts until the rail is back at the start level, and the select then returns to 00.
- R5: During recharge the select is 11 (self-supply) only while the synchronised switch-off flag is 1. It is 00 while the switch is on.
- R6: A synchronised undervoltage flag forces run enable to 0 and gate hold to 1 in the same clock cycle it is seen. If the drain is low, the select then stays 00. If the drain is high, charging restarts.
- R7: In external-supply mode (ext_supply_i = 1), the select stays 00 while running, even with the rail below the recharge level.
- R8: Each comparator input passes through a two-stage synchroniser. A change on a pin has no effect on the outputs after one clock edge and takes effect after the second edge.
- R9: Synchronous active-high reset puts the block in the off state: select 00, run enable 0, gate hold 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| drain_hi_i | input | 1 | Drain voltage above the start threshold of the source |
| vcc_gt1_i | input | 1 | Supply rail above 1 V |
| vcc_gt_start_i | input | 1 | Supply rail at or above the start level |
| vcc_lt_rchg_i | input | 1 | Supply rail below the recharge level |
| vcc_lt_uvlo_i | input | 1 | Supply rail below the undervoltage level |
| sw_off_i | input | 1 | Main switch is in its off phase |
| ext_supply_i | input | 1 | 1 = external supply mode, 0 = self-supply mode (static) |
| chg_sel_o | output | 2 | Charging current: 00 off, 01 low, 10 medium, 11 self-supply |
| run_en_o | output | 1 | Controller allowed to switch |
| gate_hold_o | output | 1 | Hold the power gate low |

## Verification
The main sequence is driven as a rising rail, once with the drain high and once with it low. This separates charging that is gated by the drain from charging that starts on rail level alone, and shows the low-to-medium step at 1 V. A sagging rail is then applied with the switch-off flag toggling, in both supply modes. This tells the self-supply recharge apart from the external-mode idle, and off-phase delivery apart from on-phase blanking. Undervoltage is applied with the drain high and with it low, which separates restart from a held-off stop. The run-enable drop is sampled one edge and two edges after the pin changes, which pins down the synchroniser depth and the same-cycle cutoff.

// File: rtl/hv_supply_pkg.sv
package hv_supply_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_CHG_LOW   = 3'd1,
        ST_CHG_HIGH  = 3'd2,
        ST_RUN_IDLE  = 3'd3,
        ST_RUN_RECHG = 3'd4,
        ST_UVLO      = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        SEL_OFF  = 2'b00,
        SEL_LOW  = 2'b01,
        SEL_MED  = 2'b10,
        SEL_SELF = 2'b11
    } chg_sel_e;

    // Level flags used by the state machine (MSB first)
    typedef struct packed {
        logic drain_hi;
        logic vcc_gt1;
        logic vcc_gt_start;
        logic vcc_lt_rchg;
        logic vcc_lt_uvlo;
    } lvl_flags_t;

    localparam int unsigned LVL_BITS  = $bits(lvl_flags_t);
    localparam int unsigned NUM_FLAGS = LVL_BITS + 1;   // plus switch-off phase

    function automatic seq_state_e charge_entry(input lvl_flags_t f);
        return f.vcc_gt1 ? ST_CHG_HIGH : ST_CHG_LOW;
    endfunction

    function automatic logic is_run(input seq_state_e s);
        return (s == ST_RUN_IDLE) || (s == ST_RUN_RECHG);
    endfunction

endpackage

// File: rtl/hv_flag_sync.sv
module hv_flag_sync #(
    parameter int unsigned WIDTH  = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[LAST];
endmodule

// File: rtl/hv_seq_fsm.sv
module hv_seq_fsm
    import hv_supply_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lvl_flags_t lvl_i,
    input  logic       ext_supply_i,
    output seq_state_e state_o
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF, ST_UVLO: begin
                if (lvl_i.drain_hi) state_d = charge_entry(lvl_i);
            end
            ST_CHG_LOW: begin
                if (!lvl_i.drain_hi)    state_d = ST_OFF;
                else if (lvl_i.vcc_gt1) state_d = ST_CHG_HIGH;
            end
            ST_CHG_HIGH: begin
                if (lvl_i.vcc_gt_start)  state_d = ST_RUN_IDLE;
                else if (!lvl_i.drain_hi) state_d = ST_OFF;
            end
            ST_RUN_IDLE: begin
                if (lvl_i.vcc_lt_uvlo)
                    state_d = ST_UVLO;
                else if (!ext_supply_i && lvl_i.vcc_lt_rchg && lvl_i.drain_hi)
                    state_d = ST_RUN_RECHG;
            end
            ST_RUN_RECHG: begin
                if (lvl_i.vcc_lt_uvlo)
                    state_d = ST_UVLO;
                else if (ext_supply_i || lvl_i.vcc_gt_start)
                    state_d = ST_RUN_IDLE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/hv_seq_outdec.sv
module hv_seq_outdec
    import hv_supply_pkg::*;
(
    input  seq_state_e state_i,
    input  logic       uvlo_s_i,
    input  logic       sw_off_s_i,
    output chg_sel_e   chg_sel_o,
    output logic       run_en_o,
    output logic       gate_hold_o
);
    always_comb begin
        unique case (state_i)
            ST_CHG_LOW:   chg_sel_o = SEL_LOW;
            ST_CHG_HIGH:  chg_sel_o = SEL_MED;
            ST_RUN_RECHG: chg_sel_o = sw_off_s_i ? SEL_SELF : SEL_OFF;
            default:      chg_sel_o = SEL_OFF;
        endcase
    end

    assign run_en_o    = is_run(state_i) && !uvlo_s_i;
    assign gate_hold_o = !run_en_o;
endmodule

// File: rtl/hv_supply_seq.sv
module hv_supply_seq
    import hv_supply_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       drain_hi_i,
    input  logic       vcc_gt1_i,
    input  logic       vcc_gt_start_i,
    input  logic       vcc_lt_rchg_i,
    input  logic       vcc_lt_uvlo_i,
    input  logic       sw_off_i,
    input  logic       ext_supply_i,
    output logic [1:0] chg_sel_o,
    output logic       run_en_o,
    output logic       gate_hold_o
);
    logic [NUM_FLAGS-1:0] raw_flags, sync_flags;
    lvl_flags_t           lvl_s;
    logic                 sw_off_s;
    seq_state_e           state_q;
    chg_sel_e             sel;

    assign raw_flags = {drain_hi_i, vcc_gt1_i, vcc_gt_start_i,
                        vcc_lt_rchg_i, vcc_lt_uvlo_i, sw_off_i};

    hv_flag_sync #(
        .WIDTH  (NUM_FLAGS),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_flags),
        .sync_o  (sync_flags)
    );

    assign lvl_s    = lvl_flags_t'(sync_flags[NUM_FLAGS-1:1]);
    assign sw_off_s = sync_flags[0];

    hv_seq_fsm fsm_i (
        .clk          (clk),
        .rst          (rst),
        .lvl_i        (lvl_s),
        .ext_supply_i (ext_supply_i),
        .state_o      (state_q)
    );

    hv_seq_outdec dec_i (
        .state_i     (state_q),
        .uvlo_s_i    (lvl_s.vcc_lt_uvlo),
        .sw_off_s_i  (sw_off_s),
        .chg_sel_o   (sel),
        .run_en_o    (run_en_o),
        .gate_hold_o (gate_hold_o)
    );

    assign chg_sel_o = sel;
endmodule

// File: rtl/hv_supply_seq_chk.sv
module hv_supply_seq_chk
    import hv_supply_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input seq_state_e state_q,
    input lvl_flags_t lvl_s,
    input logic       sw_off_i,
    input logic       ext_supply_i,
    input logic [1:0] chg_sel_o,
    input logic       run_en_o,
    input logic       gate_hold_o
);
    AST_NO_START_WITHOUT_DRAIN: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_OFF || state_q == ST_UVLO) && !lvl_s.drain_hi) |=> (chg_sel_o == SEL_OFF)); // R1

    AST_LOW_TO_MED_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHG_LOW && lvl_s.drain_hi && lvl_s.vcc_gt1) |=> (chg_sel_o == SEL_MED)); // R2

    AST_RUN_NO_STARTUP_CURRENT: assert property (@(posedge clk) disable iff (rst)
        run_en_o |-> (chg_sel_o == SEL_OFF || chg_sel_o == SEL_SELF)); // R3

    AST_SELF_ONLY_SWITCH_OFF: assert property (@(posedge clk) disable iff (rst)
        (chg_sel_o == SEL_SELF) |-> $past(sw_off_i, 2)); // R5

    AST_UVLO_STOPS_RUN: assert property (@(posedge clk) disable iff (rst)
        lvl_s.vcc_lt_uvlo |-> (!run_en_o && gate_hold_o)); // R6

    AST_EXT_NO_RECHARGE: assert property (@(posedge clk) disable iff (rst)
        (ext_supply_i && $past(ext_supply_i)) |-> (chg_sel_o != SEL_SELF)); // R7
endmodule

bind hv_supply_seq hv_supply_seq_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .state_q      (state_q),
    .lvl_s        (lvl_s),
    .sw_off_i     (sw_off_i),
    .ext_supply_i (ext_supply_i),
    .chg_sel_o    (chg_sel_o),
    .run_en_o     (run_en_o),
    .gate_hold_o  (gate_hold_o)
);

// File: tb/hv_supply_seq_tb_top.sv
`timescale 1ns/1ps
module hv_supply_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       drain_hi = 0, gt1 = 0, gt_start = 0, lt_rchg = 0, lt_uvlo = 0;
    logic       sw_off = 0, ext = 0;
    logic [1:0] chg_sel;
    logic       run_en, gate_hold;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    hv_supply_seq dut_i (
        .clk            (clk),
        .rst            (rst),
        .drain_hi_i     (drain_hi),
        .vcc_gt1_i      (gt1),
        .vcc_gt_start_i (gt_start),
        .vcc_lt_rchg_i  (lt_rchg),
        .vcc_lt_uvlo_i  (lt_uvlo),
        .sw_off_i       (sw_off),
        .ext_supply_i   (ext),
        .chg_sel_o      (chg_sel),
        .run_en_o       (run_en),
        .gate_hold_o    (gate_hold)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input int sel, input int en);
        chk({tag, " sel"}, chg_sel, sel);
        chk({tag, " run_en"}, run_en, en);
        chk({tag, " gate_hold"}, gate_hold, !en);
    endtask

    // two sync edges plus one state edge, then sample mid-cycle
    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {drain_hi, gt1, gt_start, lt_rchg, lt_uvlo, sw_off} = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk_out("R9 reset", 0, 0);
    endtask

    // bring controller to running from a discharged rail
    task automatic t_startup();
        do_reset();
        gt1 = 1; settle();
        chk_out("R1 no drain", 0, 0);
        gt1 = 0; settle();
        drain_hi = 1; settle();
        chk_out("R2 low current", 1, 0);
        gt1 = 1; settle();
        chk_out("R2 medium current", 2, 0);
        gt_start = 1; settle();
        chk_out("R3 running", 0, 1);
    endtask

    task automatic t_drain_drop();
        do_reset();
        drain_hi = 1; settle();
        chk_out("R2 low before drop", 1, 0);
        drain_hi = 0; settle();
        chk_out("R1 drop from low", 0, 0);
        drain_hi = 1; gt1 = 1; settle();
        chk_out("R2 direct medium", 2, 0);
        drain_hi = 0; settle();
        chk_out("R1 drop from medium", 0, 0);
    endtask

    task automatic t_recharge();
        ext = 0;
        t_startup();
        sw_off = 1; gt_start = 0; settle();
        chk_out("R4 sag above recharge", 0, 1);
        lt_rchg = 1; settle();
        chk_out("R5 recharge switch off", 3, 1);
        sw_off = 0; settle();
        chk_out("R5 recharge switch on", 0, 1);
        sw_off = 1; settle();
        chk_out("R5 recharge again off", 3, 1);
        lt_rchg = 0; settle();
        chk_out("R4 still recharging", 3, 1);
        gt_start = 1; settle();
        chk_out("R4 recharge done", 0, 1);
    endtask

    task automatic t_external();
        ext = 1;
        t_startup();
        sw_off = 1; gt_start = 0; lt_rchg = 1; settle();
        chk_out("R7 external below recharge", 0, 1);
        repeat (10) @(negedge clk);
        chk_out("R7 external held", 0, 1);
        ext = 0;
    endtask

    task automatic t_uvlo_drain_hi();
        ext = 0;
        t_startup();
        gt_start = 0;
        @(negedge clk);
        lt_uvlo = 1;
        @(posedge clk); @(negedge clk);
        chk("R8 one edge no effect", run_en, 1);
        @(posedge clk); @(negedge clk);
        chk("R6 same cycle run_en", run_en, 0);
        chk("R6 same cycle gate_hold", gate_hold, 1);
        chk("R8 two edges", chg_sel, 0);
        repeat (2) @(posedge clk); @(negedge clk);
        chk_out("R6 restart charge", 2, 0);
        lt_uvlo = 0;
    endtask

    task automatic t_uvlo_drain_lo();
        ext = 0;
        t_startup();
        drain_hi = 0; gt_start = 0; settle();
        chk_out("R6 running drain low", 0, 1);
        lt_uvlo = 1; settle();
        chk_out("R6 uvlo drain low", 0, 0);
        repeat (10) @(negedge clk);
        chk_out("R6 uvlo held off", 0, 0);
        drain_hi = 1; settle();
        chk_out("R6 uvlo drain back", 2, 0);
        lt_uvlo = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_startup();
        t_drain_drop();
        t_recharge();
        t_external();
        t_uvlo_drain_hi();
        t_uvlo_drain_lo();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule